// File: doc/BRIEF.md
# Flash-Semantics Word Memory Emulator

This block is a small synthesizable memory that behaves like a NOR-style flash array, so that flash controllers can be exercised against it in simulation or on a prototype. Storage is split into erase blocks, and each block holds a fixed number of words. A one-bit request strobe, a two-bit command code and an address drive the block. Reads are random access by word. Programs are random access by word. Erase works only on a whole block.

A program never sets a bit. The stored word becomes the old word ANDed with the supplied word. The only way to bring bits back to one is an erase of the whole block, and that erase takes far more cycles than a program. While a program or an erase is running, `busy_o` is high and every new request is dropped. When the operation ends, `done_o` pulses once. A program that asks for a 0-to-1 change is still stored as the AND result. Its completion carries a `prog_violation_o` pulse so that the controller under test can be flagged.

Top module: `flash_emu`

## Requirements
- R1: After reset every word of every block reads as all ones, and `busy_o`, `done_o`, `rvalid_o` and `prog_violation_o` are low.
- R2: `cmd_i` = 2'b01 with `req_i` high while idle is a read. `rdata_o` holds the word at `addr_i` and `rvalid_o` is high for exactly the one cycle after the request edge.
- R3: `cmd_i` = 2'b10 with `req_i` high while idle is a program. `busy_o` is high for exactly PROG_CYCLES cycles starting after the request edge. Then the stored word equals the old word AND `wdata_i`, and `done_o` is high for the one cycle after `busy_o` falls.
- R4: A sequence of programs to one word, in which each new value clears a superset of the bits already cleared (for example low nibble 1111 → 1110 → 1010 → 0010 → 0000), stores each value exactly and raises no violation.
- R5: When a program's (~old & new) is nonzero, `prog_violation_o` is high in the same cycle as that program's `done_o`, and the AND result is still stored. A program with no such bit leaves `prog_violation_o` low.
- R6: `cmd_i` = 2'b11 with `req_i` high while idle erases the block selected by the upper address bits. `busy_o` is high for exactly ERASE_CYCLES cycles, and `done_o` pulses once after it. Every word of that block then reads as all ones, and words in other blocks keep their contents.
- R7: While `busy_o` is high, requests of any kind are ignored. A read returns no `rvalid_o`, a program changes no word, and no operation starts after the current one ends.
- R8: `cmd_i` = 2'b00 is a no-op. It produces no `rvalid_o`, no `busy_o` and no `done_o`. The address splits into a block index (upper bits) and a word index (lower bits). With the defaults, `addr_i[5:4]` selects one of 4 blocks and `addr_i[3:0]` selects one of 16 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Command strobe, sampled each rising edge |
| cmd_i | input | 2 | 00 no-op, 01 read, 10 program, 11 block erase |
| addr_i | input | ADDR_W | Block index in upper bits, word index in lower bits |
| wdata_i | input | WORD_W | Program data |
| rdata_o | output | WORD_W | Read data |
| rvalid_o | output | 1 | Read data valid, one-cycle pulse |
| busy_o | output | 1 | Program or erase in progress |
| done_o | output | 1 | Program or erase finished, one-cycle pulse |
| prog_violation_o | output | 1 | Finished program asked for a 0-to-1 change |

## Verification
The program path is tried with four kinds of data. The first is a chain of monotonically clearing values on one word, which separates a true AND merge from a plain overwrite or an OR. The second is a value that re-raises cleared bits, which shows whether the violation flag fires and whether the AND result is still stored. The third is an all-ones write that must change nothing. The fourth is a set of writes to words in different blocks, which shows that the address decode keeps blocks apart. A block erase followed by reads inside and outside the erased block separates whole-block reset from global or single-word reset. Requests issued during an erase separate true dropping from queuing or from running ahead.

// File: rtl/flash_emu_pkg.sv
package flash_emu_pkg;
  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_READ  = 2'b01,
    OP_PROG  = 2'b10,
    OP_ERASE = 2'b11
  } op_e;
endpackage

// File: rtl/flash_emu_merge.sv
module flash_emu_merge #(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] old_i,
  input  logic [WORD_W-1:0] new_i,
  output logic [WORD_W-1:0] merged_o,
  output logic              viol_o
);
  // cells only discharge: a 1 in new over a 0 in old cannot be honoured
  assign merged_o = old_i & new_i;
  assign viol_o   = |(~old_i & new_i);
endmodule

// File: rtl/flash_emu_array.sv
module flash_emu_array #(
  parameter int WORD_W   = 16,
  parameter int WPB      = 16,
  parameter int NUM_BLKS = 4,
  localparam int BLK_W   = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1,
  localparam int WRD_W   = (WPB > 1) ? $clog2(WPB) : 1,
  localparam int ADDR_W  = BLK_W + WRD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              prog_en_i,
  input  logic [WORD_W-1:0] prog_data_i,
  input  logic              erase_en_i
);
  logic [BLK_W-1:0] rd_blk, wr_blk;
  logic [WRD_W-1:0] rd_wrd, wr_wrd;
  logic [NUM_BLKS-1:0][WORD_W-1:0] blk_rd;

  assign rd_blk = rd_addr_i[ADDR_W-1:WRD_W];
  assign rd_wrd = rd_addr_i[WRD_W-1:0];
  assign wr_blk = wr_addr_i[ADDR_W-1:WRD_W];
  assign wr_wrd = wr_addr_i[WRD_W-1:0];

  for (genvar b = 0; b < NUM_BLKS; b++) begin : g_blk
    logic [WORD_W-1:0] mem [WPB];
    logic              hit;

    assign hit = (wr_blk == BLK_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int w = 0; w < WPB; w++) mem[w] <= '1;
      end else if (erase_en_i && hit) begin
        for (int w = 0; w < WPB; w++) mem[w] <= '1;
      end else if (prog_en_i && hit) begin
        mem[wr_wrd] <= prog_data_i;
      end
    end

    assign blk_rd[b] = mem[rd_wrd];
  end

  assign rd_data_o = blk_rd[rd_blk];
endmodule

// File: rtl/flash_emu_ctrl.sv
module flash_emu_ctrl
  import flash_emu_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int WORD_W       = 16,
  parameter int PROG_CYCLES  = 4,
  parameter int ERASE_CYCLES = 64,
  localparam int MAXC  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES,
  localparam int CNT_W = $clog2(MAXC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  op_e               cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              rd_acc_o,
  output logic              commit_prog_o,
  output logic              commit_erase_o,
  output logic [ADDR_W-1:0] lat_addr_o,
  output logic [WORD_W-1:0] lat_data_o
);
  logic              busy_q;
  logic              is_erase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] lat_addr_q;
  logic [WORD_W-1:0] lat_data_q;
  logic              idle_req, start_prog, start_erase, last;

  assign idle_req    = req_i && !busy_q;
  assign rd_acc_o    = idle_req && (cmd_i == OP_READ);
  assign start_prog  = idle_req && (cmd_i == OP_PROG);
  assign start_erase = idle_req && (cmd_i == OP_ERASE);
  assign last        = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      is_erase_q <= 1'b0;
      cnt_q      <= '0;
      lat_addr_q <= '0;
      lat_data_q <= '1;
    end else if (start_prog || start_erase) begin
      busy_q     <= 1'b1;
      is_erase_q <= start_erase;
      cnt_q      <= start_erase ? CNT_W'(ERASE_CYCLES - 1) : CNT_W'(PROG_CYCLES - 1);
      lat_addr_q <= addr_i;
      lat_data_q <= wdata_i;
    end else if (busy_q) begin
      if (last) busy_q <= 1'b0;
      else      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o         = busy_q;
  assign commit_prog_o  = last && !is_erase_q;
  assign commit_erase_o = last && is_erase_q;
  assign lat_addr_o     = lat_addr_q;
  assign lat_data_o     = lat_data_q;

  // R7
  lat_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> (!busy_q || ($stable(lat_addr_q) && $stable(lat_data_q))));

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (int'(cnt_q) < MAXC));

  // R6
  one_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_prog_o || commit_erase_o) |=> !(commit_prog_o || commit_erase_o));
endmodule

// File: rtl/flash_emu.sv
module flash_emu
  import flash_emu_pkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int WPB          = 16,
  parameter int NUM_BLKS     = 4,
  parameter int PROG_CYCLES  = 4,
  parameter int ERASE_CYCLES = 64,
  localparam int BLK_W  = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1,
  localparam int WRD_W  = (WPB > 1) ? $clog2(WPB) : 1,
  localparam int ADDR_W = BLK_W + WRD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              prog_violation_o
);
  logic              busy, rd_acc, commit_prog, commit_erase, viol;
  logic [ADDR_W-1:0] lat_addr, rd_addr;
  logic [WORD_W-1:0] lat_data, rd_data, merged;
  logic [WORD_W-1:0] rdata_q;
  logic              rvalid_q, done_q, viol_q;

  flash_emu_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) i_ctrl (
    .clk_i, .rst_ni, .req_i,
    .cmd_i          (op_e'(cmd_i)),
    .addr_i, .wdata_i,
    .busy_o         (busy),
    .rd_acc_o       (rd_acc),
    .commit_prog_o  (commit_prog),
    .commit_erase_o (commit_erase),
    .lat_addr_o     (lat_addr),
    .lat_data_o     (lat_data)
  );

  // single read port: the host while idle, the merge path while busy
  assign rd_addr = busy ? lat_addr : addr_i;

  flash_emu_array #(
    .WORD_W(WORD_W), .WPB(WPB), .NUM_BLKS(NUM_BLKS)
  ) i_array (
    .clk_i, .rst_ni,
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data),
    .wr_addr_i   (lat_addr),
    .prog_en_i   (commit_prog),
    .prog_data_i (merged),
    .erase_en_i  (commit_erase)
  );

  flash_emu_merge #(.WORD_W(WORD_W)) i_merge (
    .old_i    (rd_data),
    .new_i    (lat_data),
    .merged_o (merged),
    .viol_o   (viol)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '1;
      rvalid_q <= 1'b0;
      done_q   <= 1'b0;
      viol_q   <= 1'b0;
    end else begin
      rvalid_q <= rd_acc;
      if (rd_acc) rdata_q <= rd_data;
      done_q   <= commit_prog || commit_erase;
      viol_q   <= commit_prog && viol;
    end
  end

  assign rdata_o          = rdata_q;
  assign rvalid_o         = rvalid_q;
  assign busy_o           = busy;
  assign done_o           = done_q;
  assign prog_violation_o = viol_q;

  // R2
  rvalid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> !busy_o);

  // R2
  rvalid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && cmd_i == 2'b01) |=> rvalid_o);

  // R3
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R5
  viol_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_violation_o |-> done_o);

  // R7
  busy_drop_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_i) |=> !rvalid_o);
endmodule

// File: tb/test_flash_emu.sv
module test_flash_emu;
  localparam int WORD_W = 16;
  localparam int WPB = 16;
  localparam int NUM_BLKS = 4;
  localparam int PROG_CYCLES = 4;
  localparam int ERASE_CYCLES = 64;
  localparam int ADDR_W = 6;

  typedef struct packed {
    logic [5:0]  addr;
    logic [15:0] data;
    logic [15:0] exp;
    logic        viol;
  } vec_t;

  // programs followed by read-back; R4 chain on word 0, R5 re-raise, block spread
  localparam vec_t VECS [8] = '{
    '{6'h00, 16'hFFFE, 16'hFFFE, 1'b0},
    '{6'h00, 16'hFFFA, 16'hFFFA, 1'b0},
    '{6'h00, 16'hFFF2, 16'hFFF2, 1'b0},
    '{6'h00, 16'hFFF0, 16'hFFF0, 1'b0},
    '{6'h00, 16'h00FF, 16'h00F0, 1'b1},
    '{6'h15, 16'hA5A5, 16'hA5A5, 1'b0},
    '{6'h3F, 16'h1234, 16'h1234, 1'b0},
    '{6'h2A, 16'hFFFF, 16'hFFFF, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0;
  logic [1:0]        cmd = 2'b00;
  logic [ADDR_W-1:0] addr = '0;
  logic [WORD_W-1:0] wdata = '0;
  logic [WORD_W-1:0] rdata;
  logic              rvalid, busy, done, viol;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  flash_emu #(
    .WORD_W(WORD_W), .WPB(WPB), .NUM_BLKS(NUM_BLKS),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) i_flash_emu (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .cmd_i(cmd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .busy_o(busy), .done_o(done), .prog_violation_o(viol)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] c, input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d);
    @(negedge clk);
    req = 1'b1; cmd = c; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; cmd = 2'b00;
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] exp, input string tag);
    issue(2'b01, a, '0);
    chk(rvalid === 1'b1, {tag, " rvalid"}, int'(rvalid), 1);
    chk(rdata === exp, {tag, " rdata"}, int'(rdata), int'(exp));
    @(negedge clk);
    chk(rvalid === 1'b0, {tag, " rvalid one cycle"}, int'(rvalid), 0);
  endtask

  task automatic wait_done(input int exp_n, input logic exp_v, input string tag);
    int n = 0;
    while (busy === 1'b1 && n < 1000) begin
      n++;
      @(negedge clk);
    end
    if (exp_n > 0) chk(n == exp_n, {tag, " busy cycles"}, n, exp_n);
    chk(done === 1'b1, {tag, " done"}, int'(done), 1);
    chk(viol === exp_v, {tag, " violation"}, int'(viol), int'(exp_v));
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, {tag, " done one cycle"}, int'({done, busy}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0 && done === 1'b0 && rvalid === 1'b0 && viol === 1'b0,
        "R1 outputs idle", int'({busy, done, rvalid, viol}), 0);
    do_read(6'h00, 16'hFFFF, "R1 blk0 erased");
    do_read(6'h2A, 16'hFFFF, "R1 blk2 erased");
    do_read(6'h3F, 16'hFFFF, "R1 blk3 erased");

    // R3 R4 R5 table walk
    for (int i = 0; i < 8; i++) begin
      issue(2'b10, VECS[i].addr, VECS[i].data);
      chk(busy === 1'b1, "R3 busy after program", int'(busy), 1);
      wait_done(PROG_CYCLES, VECS[i].viol, VECS[i].viol ? "R5 program" : "R4 program");
      do_read(VECS[i].addr, VECS[i].exp, VECS[i].viol ? "R5 AND stored" : "R3 read back");
    end

    // R6 erase block 0 only
    issue(2'b11, 6'h07, '0);
    wait_done(ERASE_CYCLES, 1'b0, "R6 erase");
    do_read(6'h00, 16'hFFFF, "R6 erased word");
    do_read(6'h15, 16'hA5A5, "R6 other block kept");
    do_read(6'h3F, 16'h1234, "R6 other block kept");

    // R7 requests dropped during erase of block 1
    issue(2'b11, 6'h10, '0);
    repeat (2) @(negedge clk);
    issue(2'b01, 6'h3F, '0);
    chk(rvalid === 1'b0, "R7 read while busy", int'(rvalid), 0);
    issue(2'b10, 6'h3F, 16'h0000);
    chk(busy === 1'b1, "R7 still erasing", int'(busy), 1);
    wait_done(0, 1'b0, "R7 erase end");
    chk(busy === 1'b0, "R7 nothing queued", int'(busy), 0);
    do_read(6'h3F, 16'h1234, "R7 program dropped");
    do_read(6'h15, 16'hFFFF, "R6 block1 erased");

    // R8 no-op
    issue(2'b00, 6'h00, 16'h0000);
    chk(rvalid === 1'b0 && busy === 1'b0 && done === 1'b0, "R8 no-op",
        int'({rvalid, busy, done}), 0);
    do_read(6'h00, 16'hFFFF, "R8 no-op left data");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule